// File: doc/BRIEF.md
# Serial EEPROM Target on a Two-Wire Bus

This block is a synchronous two-wire (I2C) target that behaves like a byte-addressed serial EEPROM. It runs on a system clock much faster than the bus clock. It oversamples SCL and SDA and recognises START and STOP from the relative order of their edges. It accepts a device address built from a fixed `1010` prefix and three strap pins. It then serves writes, which are two memory-address bytes followed by data bytes held in a page buffer. It also serves reads, which stream bytes from an address pointer. It never drives SDA high. It only asserts a pull-low enable, which the pad ring turns into an open-drain driver.

A STOP that closes a write carrying at least one accepted data byte launches an internal write cycle. That cycle lasts a parameterised number of clocks. It copies the buffered bytes into an inferred array. While the cycle runs, the block refuses its own address, so a master can poll for completion. A write-lock input keeps bytes out of the buffer while data transfer continues normally on the bus.

The FSM has six states:

- `S_IDLE`: ignore the bus.
- `S_RECV`: shift in a byte. A kind tag marks it as the device byte, the high address byte, the low address byte or a data byte.
- `S_ACK`: hold SDA low for the ninth clock.
- `S_SEND`: shift out a byte.
- `S_MACK`: sample the master's acknowledge.
- `S_HOLD`: wait for STOP or START after the master's NACK.

The transitions are:

- START from any state goes to `S_RECV` with the device kind.
- STOP from any state goes to `S_IDLE`.
- In `S_RECV`, the falling edge after eight bits goes to `S_ACK`. For a device byte that does not match, or that arrives while busy, it goes to `S_IDLE` instead.
- In `S_ACK`, the falling edge goes to `S_SEND` after a matching read address. Otherwise it goes back to `S_RECV` with the next kind.
- In `S_SEND`, the eighth falling edge goes to `S_MACK`.
- In `S_MACK`, the falling edge goes to `S_SEND` on ACK and to `S_HOLD` on NACK.

Top module: `i2c_eeprom_target`

## Requirements
- R1: A falling SDA while SCL is high is START, and a rising SDA while SCL is high is STOP. Until the first START, any SCL clocking leaves SDA undriven.
- R2: The device byte is accepted only when bits 7..4 are `1010` and bits 3..1 equal `dev_sel[2:0]`. Bit 0 selects read (1) or write (0). Any other device byte leaves SDA undriven for the rest of the transfer.
- R3: After an accepted device byte, and after every memory-address byte and data byte of a write, `sda_pull` is high for the whole ninth SCL high period.
- R4: Incoming bits are taken on SCL rising edges. Outgoing bits change only after an SCL falling edge and stay stable while SCL is high.
- R5: A write carries the memory address as two bytes, high byte first. Only the low `ADDR_W` bits of the 16-bit value are used, and the rest are ignored.
- R6: Data bytes of one write fill a page of `2**PAGE_W` bytes. The low `PAGE_W` address bits wrap within the page, and the upper bits stay fixed.
- R7: A STOP after a write with at least one accepted data byte starts a write cycle of `WRITE_CYCLES` clocks, at least `2**PAGE_W`. During the cycle the device byte is NACKed. After the cycle, the stored bytes read back.
- R8: While `wr_lock` is high, data bytes are still acknowledged but are not stored, and no write cycle follows the STOP.
- R9: A read sends each byte MSB first and releases SDA in the ninth clock. On the master's ACK it sends the next byte. The pointer increments after every byte sent and wraps from the last location to 0.
- R10: After the master's NACK the block drives nothing until the next START or STOP.
- R11: A repeated START after the two address bytes, followed by a read device byte, reads from that address. A read without a preceding address phase continues from the current pointer.
- R12: A START that interrupts a write after data bytes discards the buffered bytes, and no write cycle follows.
- R13: Out of reset SDA is undriven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Bus clock level from the pad |
| sda_in | input | 1 | Bus data level from the pad |
| dev_sel | input | 3 | Strap pins compared with device-byte bits 3..1 |
| wr_lock | input | 1 | High inhibits storing of data bytes |
| sda_pull | output | 1 | High pulls SDA low (open-drain enable) |

## Verification
The bench builds the block with `ADDR_W = 8`, `PAGE_W = 4` and `WRITE_CYCLES = 300`. The 256-byte array lets one run cover the read wrap from the top location to zero, and ignored upper address bits are present in every high address byte. The 16-byte pages make random writes of up to 20 bytes cross the page wrap often. The short write cycle lets the bench re-address the part within the busy window and also after it has ended. Strap value `3'b101` is fixed, so mismatches in either prefix or straps can be driven.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;

    localparam logic [3:0] DEV_PREFIX = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RECV,
        S_ACK,
        S_SEND,
        S_MACK,
        S_HOLD
    } ee_state_t;

    typedef enum logic [1:0] {
        K_DEV,
        K_AHI,
        K_ALO,
        K_DATA
    } ee_kind_t;

    function automatic ee_kind_t kind_after(input ee_kind_t k);
        unique case (k)
            K_DEV:   return K_AHI;
            K_AHI:   return K_ALO;
            default: return K_DATA;
        endcase
    endfunction

endpackage

// File: rtl/i2c_ee_sync.sv
module i2c_ee_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_c,
    output logic stop_c
);
    logic [STAGES-1:0] scl_q;
    logic [STAGES-1:0] sda_q;
    logic              scl_p;
    logic              sda_p;
    logic              scl_s;
    logic              sda_s;

    // bus idles high, so the chain resets to ones
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_in};
            sda_q <= {sda_q[STAGES-2:0], sda_in};
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_s    = scl_q[STAGES-1];
    assign sda_s    = sda_q[STAGES-1];
    assign sda_lvl  = sda_s;
    assign scl_rise = scl_s & ~scl_p;
    assign scl_fall = ~scl_s & scl_p;
    // data edges while the clock stays high mark the frame boundaries
    assign start_c  = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_c   = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_ee_store.sv
module i2c_ee_store #(
    parameter int ADDR_W       = 10,
    parameter int PAGE_W       = 6,
    parameter int WRITE_CYCLES = 250000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     buf_we,
    input  logic [PAGE_W-1:0]        buf_idx,
    input  logic [ADDR_W-PAGE_W-1:0] buf_base,
    input  logic [7:0]               buf_data,
    input  logic                     buf_clr,
    input  logic                     launch,
    output logic                     busy,
    input  logic [ADDR_W-1:0]        rd_addr,
    output logic [7:0]               rd_data
);
    localparam int PAGE   = 1 << PAGE_W;
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int HOLD   = (WRITE_CYCLES > PAGE) ? WRITE_CYCLES : PAGE;
    localparam int CW     = $clog2(HOLD + 1);
    localparam int BASE_W = ADDR_W - PAGE_W;

    logic [7:0]        mem  [DEPTH];
    logic [7:0]        pbuf [PAGE];
    logic [PAGE-1:0]   pval;
    logic [BASE_W-1:0] base;
    logic [CW-1:0]     ccnt;
    logic              busy_q;
    logic              commit_on;
    logic [PAGE_W-1:0] cidx;

    assign cidx      = ccnt[PAGE_W-1:0];
    assign commit_on = busy_q && (ccnt < CW'(PAGE));

    // write-cycle timer and buffer bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            ccnt   <= '0;
            pval   <= '0;
            base   <= '0;
        end else if (busy_q) begin
            if (ccnt == CW'(HOLD - 1)) begin
                busy_q <= 1'b0;
                ccnt   <= '0;
                pval   <= '0;
            end else begin
                ccnt <= ccnt + CW'(1);
            end
        end else if (launch) begin
            busy_q <= 1'b1;
            ccnt   <= '0;
        end else begin
            if (buf_clr) pval <= '0;
            if (buf_we) begin
                pval[buf_idx] <= 1'b1;
                base          <= buf_base;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (buf_we && !busy_q) pbuf[buf_idx] <= buf_data;
    end

    // one buffered byte per clock in the first PAGE cycles of the timer
    always_ff @(posedge clk) begin
        if (commit_on && pval[cidx]) mem[{base, cidx}] <= pbuf[cidx];
    end

    assign rd_data = mem[rd_addr];
    assign busy    = busy_q;

endmodule

// File: rtl/i2c_eeprom_target.sv
module i2c_eeprom_target
    import i2c_ee_pkg::*;
#(
    parameter int ADDR_W       = 10,
    parameter int PAGE_W       = 6,
    parameter int WRITE_CYCLES = 250000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] dev_sel,
    input  logic       wr_lock,
    output logic       sda_pull
);
    localparam int BASE_W = ADDR_W - PAGE_W;

    logic sda_s, scl_rise, scl_fall, start_c, stop_c;

    i2c_ee_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .sda_lvl  (sda_s),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_c  (start_c),
        .stop_c   (stop_c)
    );

    ee_state_t         state, state_n;
    ee_kind_t          kind, kind_n;
    logic              rd_mode, rd_mode_n;
    logic              mack, mack_n;
    logic              have_data, have_data_n;
    logic [3:0]        cnt, cnt_n;
    logic [7:0]        rx_sh, rx_n;
    logic [7:0]        tx_sh, tx_n;
    logic [ADDR_W-1:0] ptr, ptr_n;

    logic              buf_we, buf_clr, launch, busy;
    logic [7:0]        rd_data;

    i2c_ee_store #(
        .ADDR_W       (ADDR_W),
        .PAGE_W       (PAGE_W),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .buf_we   (buf_we),
        .buf_idx  (ptr[PAGE_W-1:0]),
        .buf_base (ptr[ADDR_W-1:PAGE_W]),
        .buf_data (rx_sh),
        .buf_clr  (buf_clr),
        .launch   (launch),
        .busy     (busy),
        .rd_addr  (ptr),
        .rd_data  (rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= S_IDLE;
            kind      <= K_DEV;
            rd_mode   <= 1'b0;
            mack      <= 1'b0;
            have_data <= 1'b0;
            cnt       <= '0;
            rx_sh     <= '0;
            tx_sh     <= '0;
            ptr       <= '0;
        end else begin
            state     <= state_n;
            kind      <= kind_n;
            rd_mode   <= rd_mode_n;
            mack      <= mack_n;
            have_data <= have_data_n;
            cnt       <= cnt_n;
            rx_sh     <= rx_n;
            tx_sh     <= tx_n;
            ptr       <= ptr_n;
        end
    end

    // transitions and strobes
    always_comb begin
        state_n     = state;
        kind_n      = kind;
        rd_mode_n   = rd_mode;
        mack_n      = mack;
        have_data_n = have_data;
        cnt_n       = cnt;
        rx_n        = rx_sh;
        tx_n        = tx_sh;
        ptr_n       = ptr;
        buf_we      = 1'b0;
        buf_clr     = 1'b0;
        launch      = 1'b0;
        if (start_c) begin
            state_n     = S_RECV;
            kind_n      = K_DEV;
            cnt_n       = '0;
            buf_clr     = have_data;
            have_data_n = 1'b0;
        end else if (stop_c) begin
            state_n     = S_IDLE;
            launch      = have_data;
            have_data_n = 1'b0;
        end else begin
            unique case (state)
                S_IDLE: begin
                end
                S_RECV: begin
                    if (scl_rise && cnt != 4'd8) begin
                        rx_n  = {rx_sh[6:0], sda_s};
                        cnt_n = cnt + 4'd1;
                    end else if (scl_fall && cnt == 4'd8) begin
                        cnt_n   = '0;
                        state_n = S_ACK;
                        unique case (kind)
                            K_DEV: begin
                                if (rx_sh[7:1] == {DEV_PREFIX, dev_sel} && !busy)
                                    rd_mode_n = rx_sh[0];
                                else
                                    state_n = S_IDLE;
                            end
                            K_AHI: ptr_n = ADDR_W'({rx_sh, 8'h00});
                            K_ALO: ptr_n = ptr | ADDR_W'(rx_sh);
                            K_DATA: begin
                                if (!wr_lock) begin
                                    buf_we      = 1'b1;
                                    have_data_n = 1'b1;
                                end
                                ptr_n = {ptr[ADDR_W-1:PAGE_W],
                                         ptr[PAGE_W-1:0] + PAGE_W'(1)};
                            end
                            default: state_n = S_IDLE;
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        if (kind == K_DEV && rd_mode) begin
                            tx_n    = rd_data;
                            cnt_n   = '0;
                            state_n = S_SEND;
                        end else begin
                            kind_n  = kind_after(kind);
                            state_n = S_RECV;
                        end
                    end
                end
                S_SEND: begin
                    if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            cnt_n   = '0;
                            ptr_n   = ptr + ADDR_W'(1);
                            state_n = S_MACK;
                        end else begin
                            cnt_n = cnt + 4'd1;
                            tx_n  = {tx_sh[6:0], 1'b0};
                        end
                    end
                end
                S_MACK: begin
                    if (scl_rise) begin
                        mack_n = ~sda_s;
                    end else if (scl_fall) begin
                        if (mack) begin
                            tx_n    = rd_data;
                            state_n = S_SEND;
                        end else begin
                            state_n = S_HOLD;
                        end
                    end
                end
                S_HOLD: begin
                end
                default: state_n = S_IDLE;
            endcase
        end
    end

    // pad output
    always_comb begin
        unique case (state)
            S_ACK:   sda_pull = 1'b1;
            S_SEND:  sda_pull = ~tx_sh[7];
            default: sda_pull = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_ee_chk.sv
module i2c_ee_chk
    import i2c_ee_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input logic      scl_in,
    input logic      sda_pull,
    input ee_state_t state,
    input logic      busy,
    input logic      start_c,
    input logic      stop_c
);
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sda_pull);

    // R4
    drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_pull) |-> (!$past(scl_in) || $past(start_c) || $past(stop_c)));

    // R7
    cycle_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_c));

    // R7
    busy_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (state != S_SEND && state != S_MACK));

    // R9
    mack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_MACK) |-> !sda_pull);

    // R10
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HOLD) |=> !sda_pull);

endmodule

bind i2c_eeprom_target i2c_ee_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_pull (sda_pull),
    .state    (state),
    .busy     (busy),
    .start_c  (start_c),
    .stop_c   (stop_c)
);

// File: tb/sim_i2c_eeprom_target.sv
module sim_i2c_eeprom_target;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 8;
    localparam int PW         = 4;
    localparam int WRC        = 300;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wlock = 1'b0;
    logic sda_pull;
    logic sda_line;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [7:0] mdl [256];
    bit         known [256];
    logic [7:0] wbuf [32];

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_line = sda_m & ~sda_pull;

    i2c_eeprom_target #(
        .ADDR_W(AW), .PAGE_W(PW), .WRITE_CYCLES(WRC), .SYNC_STAGES(2)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda_line),
        .dev_sel(STRAP), .wr_lock(wlock), .sda_pull(sda_pull)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic clkn(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic put_bit(input logic b);
        clkn(4); sda_m = b; clkn(4); scl = 1'b1; clkn(8); scl = 1'b0;
    endtask

    task automatic bus_start();
        sda_m = 1'b1; clkn(4); scl = 1'b1; clkn(6); sda_m = 1'b0; clkn(6); scl = 1'b0;
    endtask

    task automatic bus_stop();
        clkn(4); sda_m = 1'b0; clkn(4); scl = 1'b1; clkn(6); sda_m = 1'b1; clkn(8);
    endtask

    // send a byte, return 1 when SDA was low at both samples of the ninth high
    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        clkn(4); sda_m = 1'b1; clkn(4); scl = 1'b1;
        clkn(1); a1 = sda_line; clkn(6); a2 = sda_line; clkn(1); scl = 1'b0;
        ack = !a1 && !a2;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b, output logic steady);
        logic s1, s2;
        steady = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            clkn(4); sda_m = 1'b1; clkn(4); scl = 1'b1;
            clkn(1); s1 = sda_line; clkn(6); s2 = sda_line; clkn(1); scl = 1'b0;
            b[i] = s2;
            if (s1 != s2) steady = 1'b0;
        end
        clkn(4); sda_m = !give_ack; clkn(4); scl = 1'b1; clkn(8); scl = 1'b0;
    endtask

    function automatic logic [7:0] dev(input logic rw);
        return {4'b1010, STRAP, rw};
    endfunction

    function automatic logic [7:0] page_addr(input logic [7:0] a, input int i);
        return {a[7:4], 4'(int'(a[3:0]) + i)};
    endfunction

    task automatic do_write(input logic [7:0] a, input int n, input logic [7:0] hi);
        logic ack;
        bus_start();
        wr_byte(dev(1'b0), ack); chk(ack, "R2 device write ack", ack, 1);
        wr_byte(hi, ack);        chk(ack, "R3 high address ack", ack, 1);
        wr_byte(a, ack);         chk(ack, "R3 low address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            wr_byte(wbuf[i], ack);
            chk(ack, "R3 data ack", ack, 1);
            if (!wlock) begin
                mdl[page_addr(a, i)]   = wbuf[i];
                known[page_addr(a, i)] = 1;
            end
        end
        bus_stop();
    endtask

    task automatic do_rand_read(input logic [7:0] a, input int n, input logic [7:0] hi, input string req);
        logic ack, st;
        logic [7:0] b;
        bus_start();
        wr_byte(dev(1'b0), ack); chk(ack, {req, " device ack"}, ack, 1);
        wr_byte(hi, ack);
        wr_byte(a, ack);
        bus_start();
        wr_byte(dev(1'b1), ack); chk(ack, "R11 read device ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            logic [7:0] ad;
            ad = 8'(int'(a) + i);
            rd_byte(i != n - 1, b, st);
            chk(st, "R4 data stable while SCL high", int'(st), 1);
            if (known[ad]) chk(b == mdl[ad], {req, " read data"}, b, mdl[ad]);
        end
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL R13 watchdog actual=timeout expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ack, st;
        logic [7:0] b;
        int seed;
        seed = $urandom(32'h5eed);
        for (int i = 0; i < 256; i++) known[i] = 0;
        clkn(5);
        // R13
        chk(sda_line == 1'b1, "R13 released in reset", sda_line, 1);
        rst_n = 1'b1;
        clkn(10);
        chk(sda_line == 1'b1, "R13 released after reset", sda_line, 1);

        // R1: clocking without START draws no acknowledge
        scl = 1'b0;
        wr_byte(dev(1'b0), ack);
        chk(!ack, "R1 no ack before START", ack, 0);

        // R2: wrong straps and wrong prefix
        bus_start();
        wr_byte({4'b1010, 3'b100, 1'b0}, ack);
        chk(!ack, "R2 strap mismatch", ack, 0);
        wr_byte(8'h00, ack);
        chk(!ack, "R2 silent after mismatch", ack, 0);
        bus_stop();
        bus_start();
        wr_byte({4'b1011, STRAP, 1'b0}, ack);
        chk(!ack, "R2 prefix mismatch", ack, 0);
        bus_stop();

        // R5 and R7: write with junk upper address bits, then poll while busy
        wbuf[0] = 8'h3C; wbuf[1] = 8'hA5; wbuf[2] = 8'h61;
        do_write(8'h12, 3, 8'h5A);
        bus_start();
        wr_byte(dev(1'b0), ack);
        chk(!ack, "R7 nack while busy", ack, 0);
        bus_stop();
        clkn(WRC + 60);
        do_rand_read(8'h12, 3, 8'hC3, "R5");

        // R6: page wrap
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33; wbuf[3] = 8'h44;
        do_write(8'h2E, 4, 8'h00);
        clkn(WRC + 60);
        do_rand_read(8'h20, 16, 8'h00, "R6");
        chk(known[8'h2F] && !known[8'h30], "R6 wrap stayed in page", int'(known[8'h30]), 0);

        // R8: locked write is acked, not stored, no write cycle
        wlock = 1'b1;
        wbuf[0] = 8'hEE; wbuf[1] = 8'hDD;
        do_write(8'h12, 2, 8'h00);
        wlock = 1'b0;
        do_rand_read(8'h12, 2, 8'h00, "R8");

        // R9: read wraps from top to zero
        wbuf[0] = 8'h9A; wbuf[1] = 8'h9B;
        do_write(8'hFE, 2, 8'h00);
        clkn(WRC + 60);
        wbuf[0] = 8'h40; wbuf[1] = 8'h41; wbuf[2] = 8'h42;
        do_write(8'h00, 3, 8'h00);
        clkn(WRC + 60);
        bus_start();
        wr_byte(dev(1'b0), ack); wr_byte(8'h00, ack); wr_byte(8'hFE, ack);
        bus_start();
        wr_byte(dev(1'b1), ack);
        for (int i = 0; i < 4; i++) begin
            logic [7:0] ad;
            ad = 8'(254 + i);
            rd_byte(i != 3, b, st);
            chk(b == mdl[ad], "R9 wrap read", b, mdl[ad]);
        end
        // R10: after NACK the line stays released
        rd_byte(1'b0, b, st);
        chk(b == 8'hFF, "R10 released after nack", b, 8'hFF);
        bus_stop();

        // R11: current-address read continues at 0x02
        bus_start();
        wr_byte(dev(1'b1), ack);
        chk(ack, "R11 current read ack", ack, 1);
        rd_byte(1'b0, b, st);
        chk(b == mdl[2], "R11 current address data", b, mdl[2]);
        bus_stop();

        // R12: START after data discards the buffer
        wbuf[0] = 8'h5E;
        do_write(8'h40, 1, 8'h00);
        clkn(WRC + 60);
        bus_start();
        wr_byte(dev(1'b0), ack); wr_byte(8'h00, ack); wr_byte(8'h40, ack);
        wr_byte(8'h77, ack);
        bus_start();
        wr_byte(dev(1'b1), ack);
        rd_byte(1'b0, b, st);
        bus_stop();
        do_rand_read(8'h40, 1, 8'h00, "R12");

        // random writes with page wrap and occasional lock
        for (int it = 0; it < 9; it++) begin
            logic [7:0] a;
            int n;
            a = 8'($urandom);
            n = 1 + int'($urandom % 20);
            wlock = (($urandom % 4) == 0);
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            do_write(a, n, 8'($urandom));
            wlock = 1'b0;
            clkn(WRC + 60);
            do_rand_read({a[7:4], 4'h0}, 18, 8'($urandom), "R6");
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule